// File: doc/BRIEF.md
# Stable Eight-Lane Argsort Unit

This block takes a packed vector of eight unsigned 16-bit elements and returns the permutation that would sort them. It does not return the sorted data. Each 16-bit lane of the result holds the index of an input lane. If the input lanes are visited in the order the result lists them, their values never decrease. When two inputs are equal, the lower-numbered lane is listed first, so the ordering is stable and fully defined.

Every lane is compared with every other lane at the same time. The lane's position in the result is the number of lanes that must come before it: the lanes holding a smaller value, plus the lower-numbered lanes holding an equal value. These positions are registered. A second stage then scatters each lane index into the output lane its position selects. The unit accepts a new vector on every cycle without stalling. Each result appears exactly two cycles after its input, marked by its own valid strobe.

Top module: `stable_argsort`

## Requirements
- R1: While reset (synchronous, active high) is applied, and on the first cycle after it, `out_valid` is 0 and `out_perm` is all zeros.
- R2: `out_valid` equals the value `in_valid` had two clock edges earlier. Vectors offered on consecutive cycles each produce a result on consecutive cycles.
- R3: Input lane j occupies bits 16j+15..16j of `in_vec`. Output lane i occupies bits 16i+15..16i of `out_perm`. Each output lane holds a value from 0 to 7, so bits 15..3 of every output lane are zero.
- R4: In a valid result, the eight output lanes together hold each of the indices 0 to 7 exactly once.
- R5: In a valid result, reading the input value at the index in output lane i, for i = 0 to 7, gives a sequence that never decreases.
- R6: When input lanes j < k hold equal values, index j appears in a lower output lane than index k.
- R7: An input whose eight lanes are all equal produces the identity result 0,1,2,...,7 in output lanes 0 to 7.
- R8: A strictly decreasing input produces 7,6,...,0 in output lanes 0 to 7.
- R9: A cycle with `in_valid` low does not change any result. `out_perm` keeps the last valid result until a new valid result arrives two cycles after the next accepted vector.
- R10: Elements are compared as unsigned numbers, so 0x8000 sorts after 0x7FFF and 0xFFFF sorts last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_vec` as a vector to sort |
| in_vec | input | 128 | Eight packed unsigned 16-bit elements |
| out_valid | output | 1 | Marks `out_perm` as a new result |
| out_perm | output | 128 | Eight packed 16-bit lanes, each holding a lane index |

## Verification
Two things can happen in the same cycle. The scatter stage can be writing out the result for one vector while the rank stage is capturing the next one, or while the rank stage is skipping an invalid slot whose data must not leak forward.

The bench provokes both. It streams vectors with `in_valid` held high or dropped at random. Some vectors draw values from a tiny range, so that ties are dense. Idle slots carry fresh data.

Each cycle, a behavioural stable sort delayed by two cycles is compared with `out_valid` and `out_perm`. Every valid result is also checked directly for ordering, stability and permutation against the input that produced it.

// File: rtl/argsort_pkg.sv
package argsort_pkg;
   localparam int unsigned DEF_LANES = 8;
   localparam int unsigned DEF_WIDTH = 16;

   // Index width for a lane count, never below one bit.
   function automatic int unsigned index_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/argsort_rank.sv
module argsort_rank #(
   parameter int unsigned LANES = argsort_pkg::DEF_LANES,
   parameter int unsigned WIDTH = argsort_pkg::DEF_WIDTH,
   parameter int unsigned IW    = argsort_pkg::index_bits(LANES)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [LANES*WIDTH-1:0] in_vec,
   output logic                  rk_valid,
   output logic [LANES*IW-1:0]   rk_flat
);
   logic [WIDTH-1:0] lane   [LANES];
   logic [IW-1:0]    rank_c [LANES];
   logic [IW-1:0]    rank_q [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign lane[g]                = in_vec[g*WIDTH +: WIDTH];
      assign rk_flat[g*IW +: IW]    = rank_q[g];
   end

   // Position of lane j = smaller values anywhere + equal values at lower lanes.
   always_comb begin
      for (int j = 0; j < LANES; j++) begin
         rank_c[j] = '0;
         for (int k = 0; k < LANES; k++) begin
            if (k != j && ((lane[k] < lane[j]) || (k < j && lane[k] == lane[j])))
               rank_c[j] = rank_c[j] + IW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rk_valid <= 1'b0;
         for (int j = 0; j < LANES; j++) rank_q[j] <= '0;
      end else begin
         rk_valid <= in_valid;
         if (in_valid) begin
            for (int j = 0; j < LANES; j++) rank_q[j] <= rank_c[j];
         end
      end
   end

   // Pairwise order of the registered positions against the sampled values.
   for (genvar j = 0; j < LANES; j++) begin : g_pj
      for (genvar k = j + 1; k < LANES; k++) begin : g_pk
         assert_tie_keeps_lane_order_R6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && lane[j] == lane[k]) |=> (rank_q[j] < rank_q[k]));
         assert_unequal_follow_value_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && lane[j] != lane[k]) |=>
               ((rank_q[j] < rank_q[k]) == $past(lane[j] < lane[k])));
      end
   end
endmodule

// File: rtl/argsort_scatter.sv
module argsort_scatter #(
   parameter int unsigned LANES = argsort_pkg::DEF_LANES,
   parameter int unsigned WIDTH = argsort_pkg::DEF_WIDTH,
   parameter int unsigned IW    = argsort_pkg::index_bits(LANES)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   rk_valid,
   input  logic [LANES*IW-1:0]    rk_flat,
   output logic                   out_valid,
   output logic [LANES*WIDTH-1:0] out_perm
);
   logic [IW-1:0]    rank   [LANES];
   logic [LANES-1:0] hit    [LANES];
   logic [IW-1:0]    pick   [LANES];
   logic [LANES*WIDTH-1:0] perm_c;

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign rank[g] = rk_flat[g*IW +: IW];
   end

   // Output lane i takes the index of whichever input lane was ranked i.
   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         pick[i] = '0;
         for (int j = 0; j < LANES; j++) begin
            hit[i][j] = (rank[j] == IW'(i));
            if (hit[i][j]) pick[i] = pick[i] | IW'(j);
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_zext
      if (WIDTH > IW) begin : g_pad
         assign perm_c[i*WIDTH +: WIDTH] = {{(WIDTH-IW){1'b0}}, pick[i]};
      end else begin : g_exact
         assign perm_c[i*WIDTH +: WIDTH] = pick[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_perm  <= '0;
      end else begin
         out_valid <= rk_valid;
         if (rk_valid) out_perm <= perm_c;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_chk
      assert_single_source_R4: assert property (@(posedge clk) disable iff (rst)
         rk_valid |-> ($countones(hit[i]) == 1));
   end

   assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
      !rk_valid |=> $stable(out_perm));
endmodule

// File: rtl/stable_argsort.sv
module stable_argsort #(
   parameter int unsigned LANES = argsort_pkg::DEF_LANES,
   parameter int unsigned WIDTH = argsort_pkg::DEF_WIDTH
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [LANES*WIDTH-1:0] in_vec,
   output logic                   out_valid,
   output logic [LANES*WIDTH-1:0] out_perm
);
   localparam int unsigned IW = argsort_pkg::index_bits(LANES);

   if (LANES < 2) begin : g_bad_lanes
      $error("stable_argsort: LANES must be at least 2");
   end
   if (WIDTH < IW) begin : g_bad_width
      $error("stable_argsort: WIDTH too narrow to hold a lane index");
   end

   logic                rk_valid;
   logic [LANES*IW-1:0] rk_flat;

   argsort_rank #(.LANES(LANES), .WIDTH(WIDTH), .IW(IW)) i_rank (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
      .rk_valid(rk_valid), .rk_flat(rk_flat)
   );

   argsort_scatter #(.LANES(LANES), .WIDTH(WIDTH), .IW(IW)) i_scatter (
      .clk(clk), .rst(rst), .rk_valid(rk_valid), .rk_flat(rk_flat),
      .out_valid(out_valid), .out_perm(out_perm)
   );

   // Cycles since reset, saturating, so the latency check never reaches into reset.
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (rst)              age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   assert_two_cycle_latency_R2: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));
endmodule

// File: tb/test_stable_argsort.sv
`timescale 1ns/1ps
module test_stable_argsort;
   localparam int L = 8;
   localparam int W = 16;
   localparam int N = L*W;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [N-1:0] in_vec = '0;
   logic out_valid;
   logic [N-1:0] out_perm;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   stable_argsort i_stable_argsort (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
      .out_valid(out_valid), .out_perm(out_perm)
   );

   // Behavioural stable sort: insertion sort on lane indices.
   function automatic logic [N-1:0] ref_perm(input logic [N-1:0] v);
      int ord[L];
      logic [N-1:0] r;
      for (int i = 0; i < L; i++) ord[i] = i;
      for (int i = 1; i < L; i++) begin
         int t;
         int p;
         t = ord[i];
         p = i - 1;
         while (p >= 0 && v[ord[p]*W +: W] > v[t*W +: W]) begin
            ord[p+1] = ord[p];
            p--;
         end
         ord[p+1] = t;
      end
      r = '0;
      for (int i = 0; i < L; i++) r[i*W +: W] = W'(ord[i]);
      return r;
   endfunction

   function automatic logic [N-1:0] pack(input int a[L]);
      logic [N-1:0] r;
      for (int i = 0; i < L; i++) r[i*W +: W] = W'(a[i]);
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Two-stage reference pipeline.
   logic         m_v1 = 1'b0, m_v2 = 1'b0;
   logic [N-1:0] m_p1 = '0, m_p2 = '0, m_i1 = '0, m_i2 = '0;
   always @(posedge clk) begin
      if (rst) begin
         m_v1 <= 1'b0; m_v2 <= 1'b0;
         m_p1 <= '0; m_p2 <= '0; m_i1 <= '0; m_i2 <= '0;
      end else begin
         m_v1 <= in_valid;
         if (in_valid) begin m_p1 <= ref_perm(in_vec); m_i1 <= in_vec; end
         m_v2 <= m_v1;
         if (m_v1) begin m_p2 <= m_p1; m_i2 <= m_i1; end
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         check(out_valid == m_v2, "R2 valid timing", N'(out_valid), N'(m_v2));
         check(out_perm == m_p2, "R9 result vs model", out_perm, m_p2);
         if (out_valid) begin
            bit zx, pm, nd, st;
            int seen;
            zx = 1'b1; pm = 1'b1; nd = 1'b1; st = 1'b1; seen = 0;
            for (int i = 0; i < L; i++) begin
               if (out_perm[i*W+3 +: W-3] != '0) zx = 1'b0;
               seen |= (1 << out_perm[i*W +: 3]);
            end
            if (seen != 8'hFF) pm = 1'b0;
            for (int i = 1; i < L; i++) begin
               int a, b;
               a = int'(out_perm[(i-1)*W +: 3]);
               b = int'(out_perm[i*W +: 3]);
               if (m_i2[a*W +: W] > m_i2[b*W +: W]) nd = 1'b0;
               if (m_i2[a*W +: W] == m_i2[b*W +: W] && a > b) st = 1'b0;
            end
            check(zx, "R3 zero-extended index", out_perm, m_p2);
            check(pm, "R4 permutation", out_perm, m_p2);
            check(nd, "R5 non-decreasing", out_perm, m_p2);
            check(st, "R6 stable ties", out_perm, m_p2);
         end
      end
   end

   task automatic send_check(input logic [N-1:0] v, input logic [N-1:0] exp, input string req);
      @(negedge clk); in_valid = 1'b1; in_vec = v;
      @(negedge clk); in_valid = 1'b0; in_vec = ~v;
      @(negedge clk);
      check(out_valid == 1'b1, req, N'(out_valid), N'(1));
      check(out_perm == exp, req, out_perm, exp);
   endtask

   initial begin
      logic [N-1:0] v;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 reset valid", N'(out_valid), '0);
      check(out_perm == '0, "R1 reset data", out_perm, '0);
      rst = 1'b0;
      @(negedge clk);
      check(out_perm == '0 && out_valid == 1'b0, "R1 after reset", out_perm, '0);

      for (int i = 0; i < L; i++) v[i*W +: W] = 16'h1234;
      send_check(v, pack('{0,1,2,3,4,5,6,7}), "R7 all equal");

      for (int i = 0; i < L; i++) v[i*W +: W] = W'(100 - 10*i);
      send_check(v, pack('{7,6,5,4,3,2,1,0}), "R8 decreasing");

      v = pack('{32'h8000, 32'h7FFF, 32'hFFFF, 32'h0000, 32'h0001, 32'h8001, 32'h7FFE, 32'hFFFE});
      send_check(v, pack('{3,4,6,1,0,5,7,2}), "R10 unsigned");

      // R9: idle slots with new data leave the result untouched.
      v = pack('{5,3,9,1,7,2,8,4});
      @(negedge clk); in_valid = 1'b1; in_vec = v;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk); in_valid = 1'b0; in_vec = pack('{c,9,8,7,6,5,4,3});
      end
      check(out_perm == pack('{3,5,1,7,0,4,6,2}), "R9 hold", out_perm, pack('{3,5,1,7,0,4,6,2}));
      check(out_valid == 1'b0, "R9 no spurious valid", N'(out_valid), '0);

      // R2: back-to-back, then random streaming with dense ties.
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         in_valid = (c < 200) ? 1'b1 : ($urandom_range(3) != 0);
         for (int i = 0; i < L; i++)
            in_vec[i*W +: W] = (c % 3 == 0) ? W'($urandom) : W'($urandom_range(3));
      end
      @(negedge clk); in_valid = 1'b0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule